// File: doc/BRIEF.md
# Eight-Bit ALU with Per-Operation Flag Masks

This block is the arithmetic and logic unit of a small register-to-register integer core. Each cycle it takes two operands, an operation code and the current status flags. One clock edge later it presents a result and an updated status vector. The carry input of the carry-using operations is the C bit of the incoming status vector.

The set of flags an operation may change is fixed per operation. A mask decoder picks those bits from the freshly computed flags. Every other bit is copied from the incoming status. Because of this, increment and decrement keep carry, the shifts keep half-carry, and nibble swap and set-all leave all six flags as they were. The operand width is a parameter with a default of 8. The half-carry point and the swap boundary sit at half that width.

Top module: `alu8_core`

## Requirements
- R1: The status vector is laid out as bit0 C, bit1 Z, bit2 N, bit3 V, bit4 S, bit5 H. The result and status outputs are registered. They show the outcome for the inputs present at the previous rising clock edge. While rst_n is low, both outputs are zero.
- R2: Add (op 0) gives A+B and add-with-carry (op 1) gives A+B+C. Both update all six flags: C is the carry out of bit 7, V is signed overflow, N is bit 7 of the result and Z is set when the result is zero.
- R3: Subtract (op 2) gives A−B and subtract-with-carry (op 3) gives A−B−C. Both update all six flags, with C set on a borrow out of bit 7 and V set on signed overflow.
- R4: For add, add-with-carry, subtract, subtract-with-carry and negate, H is the carry (for add) or borrow (for subtract) out of bit 3.
- R5: AND (op 4), OR (op 5) and XOR (op 6) update only Z, N, V and S, and V is always cleared. C and H keep their incoming values.
- R6: One's complement (op 7) gives 0xFF−A. It sets C to 1, clears V, updates Z, N and S, and keeps H.
- R7: Negate (op 8) gives 0x00−A and updates all six flags. C is set whenever the result is nonzero, and V is set only for 0x80.
- R8: Increment (op 9) and decrement (op 10) update Z, N, V and S and never change C or H. V is set for the 0x7F→0x80 and 0x80→0x7F transitions.
- R9: The following shifts and rotates update C, Z, N, V and S:
  - LSL (op 11) shifts left, inserting 0.
  - LSR (op 12) shifts right, inserting 0.
  - ROL (op 13) rotates left through carry.
  - ROR (op 14) rotates right through carry.
  - ASR (op 15) shifts right and keeps bit 7.

  The rotates insert the old C. In every case C receives the bit shifted out.
- R10: For the shifts and rotates, the new V equals N xor the new C, and H keeps its incoming value.
- R11: Swap (op 16) exchanges bits 7:4 with bits 3:0, and set-all (op 17) gives 0xFF. Neither changes any flag.
- R12: Whenever an operation updates N and V, S equals N xor V.
- R13: Any other opcode (18 to 31) returns A unchanged and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| a_i | input | W | First operand (destination operand) |
| b_i | input | W | Second operand |
| flags_i | input | 6 | Current status flags {H,S,V,N,Z,C}; bit 0 is the carry input |
| res_o | output | W | Registered result |
| flags_o | output | 6 | Registered updated status flags |

## Verification
The bound checker watches every cycle for the flag-preservation rules that hold whatever the operand values are:
- Swap, set-all and unknown opcodes copy the flags through.
- Increment and decrement keep carry.
- Logic ops clear V and complement sets C.
- Shifts tie V to N and C.
- S always matches N xor V.

The arithmetic values themselves can only be shown by the directed scenarios:
- The result bytes, carry, borrow and half-carry at nibble and byte boundaries.
- Overflow at the signed limits.
- The negate corner cases 0x00 and 0x80.
- The bits that the rotates insert.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_SWAP = 5'd16,
        OP_SET  = 5'd17
    } alu_op_e;

    localparam int NFLAGS = 6;
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    typedef logic [NFLAGS-1:0] flag_vec_t;

    localparam flag_vec_t MASK_ALL   = 6'b111111;
    localparam flag_vec_t MASK_LOGIC = 6'b011110;
    localparam flag_vec_t MASK_SHIFT = 6'b011111;
    localparam flag_vec_t MASK_NONE  = 6'b000000;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         co_o,
    output logic         hc_o,
    output logic         ov_o
);
    localparam int NIB = W / 2;

    logic [W-1:0]   b_eff;
    logic           c_eff;
    logic [W:0]     full;
    logic [NIB:0]   low;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c_eff = sub_i ? ~cin_i : cin_i;
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low   = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
        sum_o = full[W-1:0];
        co_o  = sub_i ? ~full[W] : full[W];
        hc_o  = sub_i ? ~low[NIB] : low[NIB];
        ov_o  = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    localparam int NIB = W / 2;

    always_comb begin
        res_o  = a_i;
        cout_o = cin_i;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_COM: begin
                res_o  = ~a_i;
                cout_o = 1'b1;
            end
            OP_LSL: begin
                res_o  = {a_i[W-2:0], 1'b0};
                cout_o = a_i[W-1];
            end
            OP_LSR: begin
                res_o  = {1'b0, a_i[W-1:1]};
                cout_o = a_i[0];
            end
            OP_ROL: begin
                res_o  = {a_i[W-2:0], cin_i};
                cout_o = a_i[W-1];
            end
            OP_ROR: begin
                res_o  = {cin_i, a_i[W-1:1]};
                cout_o = a_i[0];
            end
            OP_ASR: begin
                res_o  = {a_i[W-1], a_i[W-1:1]};
                cout_o = a_i[0];
            end
            OP_SWAP: res_o = {a_i[NIB-1:0], a_i[W-1:NIB]};
            OP_SET:  res_o = '1;
            default: begin
                res_o  = a_i;
                cout_o = cin_i;
            end
        endcase
    end

endmodule

// File: rtl/alu8_flagmask.sv
module alu8_flagmask
    import alu8_pkg::*;
(
    input  alu_op_e   op_i,
    output flag_vec_t mask_o
);
    always_comb begin
        case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:
                mask_o = MASK_ALL;
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:
                mask_o = MASK_LOGIC;
            OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:
                mask_o = MASK_SHIFT;
            default:
                mask_o = MASK_NONE;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [NFLAGS-1:0] flags_i,
    output logic [W-1:0]      res_o,
    output logic [NFLAGS-1:0] flags_o
);
    typedef struct packed {
        logic [W-1:0] res;
        flag_vec_t    flg;
    } alu_state_t;

    alu_op_e      op;
    logic         cin;

    logic [W-1:0] as_a;
    logic [W-1:0] as_b;
    logic         as_cin;
    logic         as_sub;
    logic [W-1:0] as_sum;
    logic         as_co;
    logic         as_hc;
    logic         as_ov;

    logic [W-1:0] bo_res;
    logic         bo_co;
    flag_vec_t    mask;

    alu_state_t   state_d;
    alu_state_t   state_q;

    assign op  = alu_op_e'(op_i);
    assign cin = flags_i[FC];

    // operand steering for the shared adder/subtractor
    always_comb begin
        as_a   = a_i;
        as_b   = b_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC: as_cin = cin;
            OP_SUB: as_sub = 1'b1;
            OP_SBC: begin
                as_sub = 1'b1;
                as_cin = cin;
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = a_i;
                as_sub = 1'b1;
            end
            OP_INC: as_b = {{(W-1){1'b0}}, 1'b1};
            OP_DEC: begin
                as_b   = {{(W-1){1'b0}}, 1'b1};
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a_i   (as_a),
        .b_i   (as_b),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .sum_o (as_sum),
        .co_o  (as_co),
        .hc_o  (as_hc),
        .ov_o  (as_ov)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .op_i   (op),
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin),
        .res_o  (bo_res),
        .cout_o (bo_co)
    );

    alu8_flagmask u_mask (
        .op_i   (op),
        .mask_o (mask)
    );

    // next-state computation
    always_comb begin
        logic      use_adder;
        logic      n_raw;
        logic      v_raw;
        logic      c_raw;
        logic      h_raw;
        flag_vec_t raw;

        use_adder = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC:
                use_adder = 1'b1;
            default: use_adder = 1'b0;
        endcase

        state_d.res = use_adder ? as_sum : bo_res;
        c_raw       = use_adder ? as_co  : bo_co;
        h_raw       = use_adder ? as_hc  : flags_i[FH];
        n_raw       = state_d.res[W-1];

        case (op)
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:
                v_raw = n_raw ^ c_raw;
            default:
                v_raw = use_adder ? as_ov : 1'b0;
        endcase

        raw[FC] = c_raw;
        raw[FZ] = (state_d.res == '0);
        raw[FN] = n_raw;
        raw[FV] = v_raw;
        raw[FS] = n_raw ^ v_raw;
        raw[FH] = h_raw;

        state_d.flg = (raw & mask) | (flags_i & ~mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_o   = state_q.res;
    assign flags_o = state_q.flg;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        op_i,
    input logic [W-1:0]      a_i,
    input logic [NFLAGS-1:0] flags_i,
    input logic [W-1:0]      res_o,
    input logic [NFLAGS-1:0] flags_o
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R11
    swap_set_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(op_i) == OP_SWAP || $past(op_i) == OP_SET))
            |-> (flags_o == $past(flags_i)));

    // R8
    incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
            |-> (flags_o[FC] == $past(flags_i[FC]) && flags_o[FH] == $past(flags_i[FH])));

    // R5
    logic_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(op_i) == OP_AND || $past(op_i) == OP_OR || $past(op_i) == OP_XOR))
            |-> (!flags_o[FV] && flags_o[FC] == $past(flags_i[FC])));

    // R6
    com_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_COM) |-> (flags_o[FC] && !flags_o[FV]));

    // R10
    shift_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) >= OP_LSL && $past(op_i) <= OP_ASR)
            |-> (flags_o[FV] == (flags_o[FN] ^ flags_o[FC])
                 && flags_o[FH] == $past(flags_i[FH])));

    // R12
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) <= OP_ASR)
            |-> (flags_o[FS] == (flags_o[FN] ^ flags_o[FV])
                 && flags_o[FN] == res_o[W-1]));

    // R13
    undef_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) > OP_SET)
            |-> (res_o == $past(a_i) && flags_o == $past(flags_i)));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        (!rst_n) |-> (res_o == '0 && flags_o == '0));

endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_alu8_core_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .a_i     (a_i),
    .flags_i (flags_i),
    .res_o   (res_o),
    .flags_o (flags_o)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic [5:0] flags_i = '0;
    logic [7:0] res_o;
    logic [5:0] flags_o;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core #(.W(8)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .flags_i (flags_i),
        .res_o   (res_o),
        .flags_o (flags_o)
    );

    task automatic check(input string req, input logic [7:0] er, input logic [5:0] ef);
        total++;
        if (res_o !== er || flags_o !== ef) begin
            bad++;
            $display("FAIL %s res=%h flags=%b expected res=%h flags=%b",
                     req, res_o, flags_o, er, ef);
        end
    endtask

    // drive at a falling edge, check at the next falling edge (one register)
    task automatic run_op(input string req, input logic [4:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [5:0] fin,
                          input logic [7:0] er, input logic [5:0] ef);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; flags_i = fin;
        @(negedge clk);
        check(req, er, ef);
    endtask

    task automatic t_reset();
        op_i = 5'd0; a_i = 8'h12; b_i = 8'h34; flags_i = 6'h3F;
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00, 6'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        run_op("R2 R4 add half carry", 5'd0, 8'h0F, 8'h01, 6'h00, 8'h10, 6'h20);
        run_op("R2 R12 add overflow to zero", 5'd0, 8'h80, 8'h80, 6'h00, 8'h00, 6'h1B);
        run_op("R2 R4 adc uses carry", 5'd1, 8'hFF, 8'h00, 6'h01, 8'h00, 6'h23);
    endtask

    task automatic t_sub();
        run_op("R3 R4 sub nibble borrow", 5'd2, 8'h10, 8'h01, 6'h00, 8'h0F, 6'h20);
        run_op("R3 sub signed overflow", 5'd2, 8'h80, 8'h01, 6'h00, 8'h7F, 6'h38);
        run_op("R3 sbc borrow chain", 5'd3, 8'h00, 8'h00, 6'h01, 8'hFF, 6'h35);
    endtask

    task automatic t_logic();
        run_op("R5 and keeps C H", 5'd4, 8'hF0, 8'h3C, 6'h3F, 8'h30, 6'h21);
        run_op("R5 R12 or negative", 5'd5, 8'h80, 8'h01, 6'h00, 8'h81, 6'h14);
        run_op("R5 xor zero", 5'd6, 8'h5A, 8'h5A, 6'h3F, 8'h00, 6'h23);
    endtask

    task automatic t_unary();
        run_op("R6 com sets carry", 5'd7, 8'h00, 8'h00, 6'h00, 8'hFF, 6'h15);
        run_op("R7 neg 0x80", 5'd8, 8'h80, 8'h00, 6'h00, 8'h80, 6'h0D);
        run_op("R7 neg zero", 5'd8, 8'h00, 8'h00, 6'h3D, 8'h00, 6'h02);
        run_op("R8 inc keeps carry", 5'd9, 8'h7F, 8'h00, 6'h01, 8'h80, 6'h0D);
        run_op("R8 dec overflow", 5'd10, 8'h80, 8'h00, 6'h00, 8'h7F, 6'h18);
        run_op("R8 dec wrap no carry", 5'd10, 8'h00, 8'h00, 6'h00, 8'hFF, 6'h14);
    endtask

    task automatic t_shift();
        run_op("R9 R10 lsl", 5'd11, 8'h81, 8'h00, 6'h00, 8'h02, 6'h19);
        run_op("R9 R10 lsr to zero", 5'd12, 8'h01, 8'h00, 6'h00, 8'h00, 6'h1B);
        run_op("R9 R10 rol inserts carry", 5'd13, 8'h40, 8'h00, 6'h01, 8'h81, 6'h0C);
        run_op("R9 R10 ror inserts carry", 5'd14, 8'h02, 8'h00, 6'h01, 8'h81, 6'h0C);
        run_op("R9 R10 asr keeps sign", 5'd15, 8'h81, 8'h00, 6'h00, 8'hC0, 6'h15);
        run_op("R10 lsl keeps H", 5'd11, 8'h01, 8'h00, 6'h20, 8'h02, 6'h20);
    endtask

    task automatic t_noflag();
        run_op("R11 swap", 5'd16, 8'hA5, 8'h00, 6'h2A, 8'h5A, 6'h2A);
        run_op("R11 set all", 5'd17, 8'h00, 8'h00, 6'h15, 8'hFF, 6'h15);
        run_op("R13 undefined op", 5'd31, 8'h3C, 8'hFF, 6'h33, 8'h3C, 6'h33);
        run_op("R13 undefined op 18", 5'd18, 8'h00, 8'h01, 6'h0C, 8'h00, 6'h0C);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_unary();
        t_shift();
        t_noflag();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule